// File: doc/BRIEF.md
# Programmable Interrupt Controller Core

This block is an eight-line interrupt controller in the 8259 style. A processor talks to it over a byte-wide register bus whose single address bit picks register port 0 or port 1. After reset, software must run an initialization sequence of two to four command bytes. That sequence fixes the trigger mode (edge or level), the vector base and whether the end of interrupt happens by itself. After that, port 1 holds the interrupt mask, and port 0 takes operation commands that retire in-service bits or choose what a port-0 read returns.

Each request line feeds a request register. The controller flags an interrupt as pending whenever an unmasked request is present. The lowest-numbered unmasked request has the highest priority, and its number, joined to the programmed base, forms the vector output. A one-cycle acknowledge strobe takes the place of the full acknowledge bus handshake: it moves the winning request into the in-service register, or simply drops it when automatic end of interrupt is selected.

Top module: `pic_core`

## Requirements
- R1: After reset, the request, in-service and mask registers are 0, `int_pend` is 0, and a port-0 read returns the request register, so it reads 0. The sequencer then waits for the first initialization byte.
- R2: A port-0 write with bit 4 set is taken as the first initialization byte in every state. It restarts the sequence, clears the mask, the in-service register and the automatic-EOI setting, and latches bit 0 (fourth byte follows), bit 1 (single, no third byte) and bit 3 (level trigger).
- R3: In the second-byte state, a port-1 write stores bits 7:3 as the vector base. The next state is the third-byte state when bit 1 was 0, else the fourth-byte state when bit 0 was 1, else ready. A port-1 write in the third-byte state moves to the fourth-byte state if bit 0 was 1 and to ready if not. A port-1 write in the fourth-byte state stores bit 1 as automatic EOI and moves to ready.
- R4: Before the ready state, port-1 writes never reach the mask, and port-0 writes with bit 4 clear are ignored.
- R5: In the ready state, a port-1 write loads the mask. A port-1 read always returns the mask.
- R6: In the ready state, a port-0 write with bits 4:3 = 01 sets the read selector from bits 1:0: 10 reads the request register, 11 reads the in-service register, and any other value makes port-0 reads return 0.
- R7: In edge mode, a request bit is set on a rising edge of its line. A line that stays high does not set the bit again after it is acknowledged.
- R8: In level mode, every request bit takes the value its line had at the previous clock edge.
- R9: `int_pend` is 1 exactly when some request bit is set whose mask bit is 0.
- R10: `vec_out` equals {base, index}, where index is the lowest-numbered unmasked set request bit, or 0 when there is none.
- R11: An `ack` with an interrupt pending clears the winning request bit (in edge mode) and, unless automatic EOI is on, sets the matching in-service bit. An `ack` with nothing pending changes nothing.
- R12: In the ready state, a port-0 write with bits 4:3 = 00 and bit 5 set ends an interrupt. With bit 6 clear it clears the lowest-numbered set in-service bit; with bit 6 set it clears the in-service bit named by bits 2:0. With bit 5 clear the write has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Port select (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the port on `addr` (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | One-cycle acknowledge strobe |
| int_pend | output | 1 | An unmasked request is present |
| vec_out | output | 8 | Vector for the current winning request |

## Verification
The bench covers each branch of the initialization path (cascaded with a fourth byte, single with a fourth byte, single with neither). A wrong branch would leave the controller expecting another byte, so a later mask write would be swallowed and the mask would read back wrong. It holds a line high across an acknowledge: a design that re-arms on the level would show the request again. It issues an acknowledge with nothing pending, a command byte with bit 5 clear, and both kinds of end of interrupt, where a wrong priority pick would leave the wrong in-service bit set. It also restarts initialization while the mask and in-service bits are nonzero, and runs automatic EOI, where a design that keeps the bit would read back a nonzero in-service register.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_DW = 8;
  localparam int PIC_N  = 8;
  localparam int PIC_IW = $clog2(PIC_N);
  localparam int PIC_BW = PIC_DW - PIC_IW;

  typedef enum logic [2:0] {
    SEQ_W1  = 3'd1,
    SEQ_W2  = 3'd2,
    SEQ_W3  = 3'd3,
    SEQ_W4  = 3'd4,
    SEQ_RDY = 3'd5
  } seq_t;

  // {found, index} of the lowest set bit
  function automatic logic [PIC_IW:0] lowest_set(input logic [PIC_N-1:0] v);
    logic [PIC_IW:0] r;
    r = '0;
    for (int i = PIC_N - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, PIC_IW'(i)};
    end
    return r;
  endfunction

  function automatic logic [PIC_N-1:0] idx_to_bit(input logic [PIC_IW-1:0] idx);
    return PIC_N'(1) << idx;
  endfunction
endpackage

// File: rtl/pic_cfg_seq.sv
module pic_cfg_seq
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [PIC_DW-1:0] wdata,
  output seq_t              seq_state,
  output logic              ltim,
  output logic              aeoi,
  output logic [PIC_BW-1:0] base,
  output logic [1:0]        rd_sel,
  output logic [PIC_N-1:0]  imr,
  output logic              icw1_hit,
  output logic              eoi_any,
  output logic              eoi_spec,
  output logic [PIC_IW-1:0] eoi_lvl
);
  logic ic4, sngl, ready, ocw_wr, p1_wr;

  always_comb begin
    ready    = (seq_state == SEQ_RDY);
    icw1_hit = wr_en && !addr && wdata[4];
    ocw_wr   = wr_en && !addr && !wdata[4] && ready;
    p1_wr    = wr_en && addr;
    eoi_any  = ocw_wr && !wdata[3] && wdata[5];
    eoi_spec = eoi_any && wdata[6];
    eoi_lvl  = wdata[PIC_IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_state <= SEQ_W1;
      ic4       <= 1'b0;
      sngl      <= 1'b0;
      ltim      <= 1'b0;
      aeoi      <= 1'b0;
      base      <= '0;
      rd_sel    <= 2'b10;
      imr       <= '0;
    end else if (icw1_hit) begin
      ic4       <= wdata[0];
      sngl      <= wdata[1];
      ltim      <= wdata[3];
      aeoi      <= 1'b0;
      imr       <= '0;
      seq_state <= SEQ_W2;
    end else if (p1_wr) begin
      case (seq_state)
        SEQ_W2: begin
          base <= wdata[PIC_DW-1:PIC_IW];
          if (!sngl)    seq_state <= SEQ_W3;
          else if (ic4) seq_state <= SEQ_W4;
          else          seq_state <= SEQ_RDY;
        end
        SEQ_W3:  seq_state <= ic4 ? SEQ_W4 : SEQ_RDY;
        SEQ_W4: begin
          aeoi      <= wdata[1];
          seq_state <= SEQ_RDY;
        end
        SEQ_RDY: imr <= wdata;
        default: ;
      endcase
    end else if (ocw_wr && wdata[3]) begin
      rd_sel <= wdata[1:0];
    end
  end
endmodule

// File: rtl/pic_req_bank.sv
module pic_req_bank
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIC_N-1:0] irq_in,
  input  logic             ltim,
  input  logic             aeoi,
  input  logic             icw1_hit,
  input  logic             take,
  input  logic [PIC_N-1:0] take_oh,
  input  logic [PIC_N-1:0] eoi_clr,
  output logic [PIC_N-1:0] irr,
  output logic [PIC_N-1:0] isr
);
  logic [PIC_N-1:0] irq_prev;

  for (genvar g = 0; g < PIC_N; g++) begin : g_line
    logic rise, grab;
    assign rise = irq_in[g] && !irq_prev[g];
    assign grab = take && take_oh[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irq_prev[g] <= 1'b0;
        irr[g]      <= 1'b0;
        isr[g]      <= 1'b0;
      end else begin
        irq_prev[g] <= irq_in[g];
        if (ltim) irr[g] <= irq_in[g];
        else      irr[g] <= (irr[g] && !grab) || rise;
        if (icw1_hit) isr[g] <= 1'b0;
        else          isr[g] <= (isr[g] && !eoi_clr[g]) || (grab && !aeoi);
      end
    end
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio
  import pic_pkg::*;
(
  input  logic [PIC_N-1:0]  irr,
  input  logic [PIC_N-1:0]  imr,
  input  logic [PIC_N-1:0]  isr,
  input  logic              eoi_any,
  input  logic              eoi_spec,
  input  logic [PIC_IW-1:0] eoi_lvl,
  output logic              pend,
  output logic [PIC_IW-1:0] win_idx,
  output logic [PIC_N-1:0]  win_oh,
  output logic [PIC_N-1:0]  eoi_clr
);
  logic [PIC_IW:0] req_pick, svc_pick;

  always_comb begin
    req_pick = lowest_set(irr & ~imr);
    svc_pick = lowest_set(isr);
    pend     = req_pick[PIC_IW];
    win_idx  = req_pick[PIC_IW-1:0];
    win_oh   = idx_to_bit(win_idx);
    eoi_clr  = '0;
    if (eoi_any) begin
      if (eoi_spec)             eoi_clr = idx_to_bit(eoi_lvl);
      else if (svc_pick[PIC_IW]) eoi_clr = idx_to_bit(svc_pick[PIC_IW-1:0]);
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [PIC_DW-1:0] wdata,
  output logic [PIC_DW-1:0] rdata,
  input  logic [PIC_N-1:0]  irq_in,
  input  logic              ack,
  output logic              int_pend,
  output logic [PIC_DW-1:0] vec_out
);
  seq_t              seq_state;
  logic              ltim, aeoi, icw1_hit, eoi_any, eoi_spec, take;
  logic [PIC_BW-1:0] base;
  logic [1:0]        rd_sel;
  logic [PIC_N-1:0]  imr, irr, isr, win_oh, eoi_clr;
  logic [PIC_IW-1:0] eoi_lvl, win_idx;

  pic_cfg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .seq_state(seq_state), .ltim(ltim), .aeoi(aeoi), .base(base),
    .rd_sel(rd_sel), .imr(imr), .icw1_hit(icw1_hit), .eoi_any(eoi_any),
    .eoi_spec(eoi_spec), .eoi_lvl(eoi_lvl)
  );

  pic_prio u_prio (
    .irr(irr), .imr(imr), .isr(isr), .eoi_any(eoi_any), .eoi_spec(eoi_spec),
    .eoi_lvl(eoi_lvl), .pend(int_pend), .win_idx(win_idx), .win_oh(win_oh),
    .eoi_clr(eoi_clr)
  );

  assign take = ack && int_pend;

  pic_req_bank u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ltim(ltim), .aeoi(aeoi),
    .icw1_hit(icw1_hit), .take(take), .take_oh(win_oh), .eoi_clr(eoi_clr),
    .irr(irr), .isr(isr)
  );

  assign vec_out = {base, win_idx};

  always_comb begin
    if (addr)                 rdata = imr;
    else if (rd_sel == 2'b10) rdata = irr;
    else if (rd_sel == 2'b11) rdata = isr;
    else                      rdata = '0;
  end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
  import pic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              addr,
  input logic [PIC_DW-1:0] wdata,
  input logic [PIC_N-1:0]  irq_in,
  input logic              ack,
  input logic              int_pend,
  input seq_t              seq_state,
  input logic              ltim,
  input logic              aeoi,
  input logic              icw1_hit,
  input logic              eoi_any,
  input logic              eoi_spec,
  input logic              take,
  input logic [PIC_IW-1:0] win_idx,
  input logic [PIC_N-1:0]  irr,
  input logic [PIC_N-1:0]  isr,
  input logic [PIC_N-1:0]  imr
);
  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_hit |=> (imr == '0) && (isr == '0));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && seq_state == SEQ_RDY) |=> imr == $past(wdata));

  assert_edge_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ltim && $rose(irq_in[0])) |=> irr[0]);

  assert_level_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ltim |=> irr == $past(irq_in));

  assert_ack_service_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !aeoi && !icw1_hit) |=> isr[$past(win_idx)]);

  assert_ack_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_pend && !icw1_hit && !eoi_any) |=> $stable(isr));

  assert_eoi_one_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_any && !eoi_spec && isr != '0 && !take) |=>
      $countones(isr) == $countones($past(isr)) - 1);
endmodule

bind pic_core pic_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_in(irq_in), .ack(ack), .int_pend(int_pend), .seq_state(seq_state),
  .ltim(ltim), .aeoi(aeoi), .icw1_hit(icw1_hit), .eoi_any(eoi_any),
  .eoi_spec(eoi_spec), .take(take), .win_idx(win_idx), .irr(irr),
  .isr(isr), .imr(imr)
);

// File: tb/test_pic_core.sv
`timescale 1ns/100ps
module test_pic_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_in = 8'h00;
  logic       ack = 1'b0;
  logic       int_pend;
  logic [7:0] vec_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pic_core i_pic_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .ack(ack), .int_pend(int_pend),
    .vec_out(vec_out)
  );

  // behavioural reference model
  logic [7:0] m_irr, m_isr, m_imr, m_prev;
  logic [4:0] m_base;
  logic [1:0] m_sel;
  bit m_ic4, m_sngl, m_ltim, m_aeoi;
  int m_st; // 1..4 = waiting for byte n, 5 = ready

  function automatic int m_win();
    for (int i = 0; i < 8; i++) if (m_irr[i] && !m_imr[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] m_read(input logic a);
    if (a) return m_imr;
    if (m_sel == 2'd2) return m_irr;
    if (m_sel == 2'd3) return m_isr;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_prev = 0; m_base = 0; m_sel = 2'd2;
      m_ic4 = 0; m_sngl = 0; m_ltim = 0; m_aeoi = 0; m_st = 1;
    end else begin
      int w;
      logic [7:0] n_irr, n_isr;
      w = m_win();
      n_irr = m_irr;
      n_isr = m_isr;
      if (m_ltim) n_irr = irq_in;
      else begin
        if (ack && w >= 0) n_irr[w] = 1'b0;
        for (int i = 0; i < 8; i++) if (irq_in[i] && !m_prev[i]) n_irr[i] = 1'b1;
      end
      if (wr_en && !addr && !wdata[4] && m_st == 5 && !wdata[3] && wdata[5]) begin
        if (wdata[6]) n_isr[wdata[2:0]] = 1'b0;
        else begin
          for (int i = 0; i < 8; i++) if (m_isr[i]) begin n_isr[i] = 1'b0; break; end
        end
      end
      if (ack && w >= 0 && !m_aeoi) n_isr[w] = 1'b1;
      if (wr_en && !addr && wdata[4]) begin
        m_ic4 = wdata[0]; m_sngl = wdata[1]; m_ltim = wdata[3]; m_aeoi = 0;
        m_imr = 0; n_isr = 0; m_st = 2;
      end else if (wr_en && addr) begin
        if (m_st == 2) begin
          m_base = wdata[7:3];
          m_st = !m_sngl ? 3 : (m_ic4 ? 4 : 5);
        end else if (m_st == 3) m_st = m_ic4 ? 4 : 5;
        else if (m_st == 4) begin m_aeoi = wdata[1]; m_st = 5; end
        else if (m_st == 5) m_imr = wdata;
      end else if (wr_en && !addr && m_st == 5 && wdata[3]) begin
        m_sel = wdata[1:0];
      end
      m_irr = n_irr;
      m_isr = n_isr;
      m_prev = irq_in;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int w;
      logic [7:0] ev;
      w = m_win();
      ev = {m_base, (w < 0) ? 3'd0 : w[2:0]};
      checks++;
      if (int_pend !== (w >= 0) || vec_out !== ev || rdata !== m_read(addr)) begin
        fails++;
        $display("FAIL R9/R10/R6 cycle compare: pend=%0b vec=%h rd=%h, expected pend=%0b vec=%h rd=%h",
                 int_pend, vec_out, rdata, (w >= 0), ev, m_read(addr));
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse_ack();
    @(posedge clk); #1;
    ack = 1'b1;
    @(posedge clk); #1;
    ack = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic a, input logic [7:0] exp);
    addr = a; #0.5;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    rd("R1 port0 after reset", 1'b0, 8'h00);
    rd("R1 mask after reset", 1'b1, 8'h00);
    chk("R1 pend after reset", {7'd0, int_pend}, 8'h00);

    wr(1'b1, 8'hFF);            // R4: ignored before init
    wr(1'b0, 8'h08);            // R4: ignored before init
    wr(1'b0, 8'h11);            // edge, cascaded, fourth byte
    wr(1'b1, 8'h40);            // base 01000
    wr(1'b1, 8'h04);            // third byte
    wr(1'b1, 8'h01);            // fourth byte, no auto EOI
    rd("R4 mask untouched by init", 1'b1, 8'h00);
    wr(1'b1, 8'hF0);
    rd("R5 mask readback", 1'b1, 8'hF0);

    irq_in = 8'h24; tick();
    rd("R7 edge request set", 1'b0, 8'h24);
    chk("R9 pending unmasked", {7'd0, int_pend}, 8'h01);
    chk("R10 vector line 2", vec_out, 8'h42);
    pulse_ack();
    wr(1'b0, 8'h0B);
    rd("R11 ack sets service bit", 1'b0, 8'h04);
    chk("R9 only masked request", {7'd0, int_pend}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R10 vector line 5", vec_out, 8'h45);
    pulse_ack();
    repeat (3) tick();
    wr(1'b0, 8'h0A);
    rd("R7 held line not re-set", 1'b0, 8'h00);
    wr(1'b0, 8'h0B);
    rd("R11 two in service", 1'b0, 8'h24);
    wr(1'b0, 8'h00);
    rd("R12 no-EOI command ignored", 1'b0, 8'h24);
    wr(1'b0, 8'h20);
    rd("R12 nonspecific EOI", 1'b0, 8'h20);
    wr(1'b0, 8'h08);
    rd("R6 selector 00 reads zero", 1'b0, 8'h00);
    wr(1'b0, 8'h0B);
    pulse_ack();
    rd("R11 ack with nothing pending", 1'b0, 8'h20);
    wr(1'b0, 8'h65);
    rd("R12 specific EOI", 1'b0, 8'h00);

    irq_in = 8'h00; tick();
    irq_in = 8'h01; tick();
    pulse_ack();
    rd("R11 line 0 in service", 1'b0, 8'h01);
    wr(1'b1, 8'h0F);
    wr(1'b0, 8'h1A);            // level, single, no fourth byte
    rd("R2 restart clears mask", 1'b1, 8'h00);
    rd("R2 restart clears service", 1'b0, 8'h00);
    wr(1'b1, 8'h88);            // base 10001 -> ready
    wr(1'b1, 8'h55);
    rd("R3 single path skips to ready", 1'b1, 8'h55);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h0A);
    rd("R8 level follows line", 1'b0, 8'h01);
    irq_in = 8'h81; tick();
    rd("R8 level new value", 1'b0, 8'h81);
    chk("R10 vector level mode", vec_out, 8'h88);
    irq_in = 8'h00; tick();
    rd("R8 level drop", 1'b0, 8'h00);

    wr(1'b0, 8'h13);            // edge, single, fourth byte
    wr(1'b1, 8'h20);            // base 00100
    wr(1'b1, 8'h03);            // auto EOI
    wr(1'b1, 8'h7E);
    rd("R3 fourth-byte path reaches ready", 1'b1, 8'h7E);
    wr(1'b1, 8'h00);
    irq_in = 8'h08; tick();
    chk("R10 vector line 3", vec_out, 8'h23);
    pulse_ack();
    wr(1'b0, 8'h0B);
    rd("R11 auto EOI keeps no service bit", 1'b0, 8'h00);
    wr(1'b0, 8'h0A);
    rd("R11 ack clears request", 1'b0, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule